// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Transmitter

This block turns one byte plus an extra ninth bit into an asynchronous serial frame of eleven bit periods. The frame starts with a low start bit. The eight data bits follow, least significant first, then the ninth bit, and then a high stop bit. The ninth bit is picked when the byte is loaded. It is either a software-supplied bit, which can mark address frames (1) and data frames (0) on a shared multi-drop line, or an even-parity bit computed from the byte.

Bit timing comes from an external one-cycle baud tick, and each bit holds the line for exactly one tick period. A load is accepted only while the transmitter is idle. The frame then starts at the next tick. A sticky done flag rises as the stop bit begins, so software can prepare the next byte while the stop bit is still on the line. The flag stays set until a clear strobe arrives.

Top module: `ninebit_uart_tx`

## Requirements
- R1: After reset `txd_o` is 1, `busy_o` is 0 and `done_o` is 0.
- R2: A `load_i` pulse while idle sets `busy_o` in the next cycle. The line stays at 1 until the next `tick_i`, and that tick begins the start bit (0).
- R3: `txd_o` changes only in the cycle after a `tick_i` pulse, so every bit lasts exactly one tick period.
- R4: Bit order on the line is start (0), D0 through D7 with the least significant bit first, the ninth bit, and then stop (1). That is eleven bit periods.
- R5: With `par_en_i` at 0 when the byte is loaded, the ninth bit equals `bit9_i` as sampled at the load. Later changes to either input have no effect on the frame.
- R6: With `par_en_i` at 1 when the byte is loaded, the ninth bit is the even-parity bit of D0..D7. The count of ones over D0..D8 is even.
- R7: `done_o` rises in the cycle after the tick that begins the stop bit. It does not rise earlier in the frame.
- R8: `done_o` holds until `clr_done_i` is pulsed and then reads 0 in the next cycle. If a set and a clear fall in the same cycle, the set wins.
- R9: A `load_i` pulse while `busy_o` is 1 is ignored. The current frame goes on unchanged, and no second frame follows it.
- R10: The tick after the stop bit ends the frame. `busy_o` drops to 0 in the next cycle, with `txd_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load strobe for a new byte |
| data_i | input | DW | Byte to send |
| bit9_i | input | 1 | Software ninth bit, used when parity is off |
| par_en_i | input | 1 | 1 selects even parity as the ninth bit |
| tick_i | input | 1 | One-cycle baud tick |
| clr_done_i | input | 1 | Clears the done flag |
| txd_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | Frame pending or in progress |
| done_o | output | 1 | Sticky flag set at the start of the stop bit |

## Verification
The bench sends every byte value under each ninth-bit source and each software bit value. It inverts `bit9_i` and `par_en_i` right after each load, so a design that reads them live instead of at load time would put the wrong ninth bit on the line. Parity is worked out by counting ones in the bench, which exposes an odd-parity or wrong-span computation. Done-flag timing is checked against both the ninth-bit period and the stop-bit period, which catches a flag raised at the end of the stop bit or one period too early. A load pulse in the middle of each frame, and a clear that collides with the set, catch a design that restarts on a busy load or lets the clear override the set.

// File: rtl/ninebit_uart_tx.sv
module ninebit_uart_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          bit9_i,
  input  logic          par_en_i,
  input  logic          tick_i,
  input  logic          clr_done_i,
  output logic          txd_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int LAST = DW + 2;
  localparam int CW = $clog2(LAST + 1);
  localparam logic [CW-1:0] IDX_STOP = CW'(LAST);
  localparam logic [CW-1:0] IDX_NINTH = CW'(LAST - 1);

  logic          busy_q, armed_q, done_q;
  logic [CW-1:0] idx_q;
  logic [DW:0]   frame_q;

  wire accept     = load_i & ~busy_q;
  wire ninth      = par_en_i ? ^data_i : bit9_i;
  wire running    = busy_q & ~armed_q;
  wire step       = running & tick_i;
  wire enter_stop = step & (idx_q == IDX_NINTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
      idx_q   <= '0;
      frame_q <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      armed_q <= 1'b1;
      idx_q   <= '0;
      frame_q <= {ninth, data_i};
    end else if (busy_q && tick_i) begin
      if (armed_q) begin
        armed_q <= 1'b0;
      end else if (idx_q == IDX_STOP) begin
        busy_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
        if (idx_q != '0) frame_q <= frame_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          done_q <= 1'b0;
    else if (enter_stop) done_q <= 1'b1;
    else if (clr_done_i) done_q <= 1'b0;
  end

  always_comb begin
    if (!running)              txd_o = 1'b1;
    else if (idx_q == '0)      txd_o = 1'b0;
    else if (idx_q == IDX_STOP) txd_o = 1'b1;
    else                       txd_o = frame_q[0];
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

module ninebit_uart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic load_i,
  input logic tick_i,
  input logic clr_done_i,
  input logic txd_o,
  input logic busy_o,
  input logic done_o
);
  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick_i) |-> $stable(txd_o)); // R3
  AST_ARM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> txd_o); // R2
  AST_DONE_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (txd_o && busy_o && $past(tick_i))); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !clr_done_i) |=> done_o); // R8
  AST_BUSY_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && load_i && !tick_i) |=> busy_o); // R9
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (txd_o && $past(tick_i))); // R10
endmodule

bind ninebit_uart_tx ninebit_uart_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .tick_i(tick_i),
  .clr_done_i(clr_done_i), .txd_o(txd_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/ninebit_uart_tx_tb_top.sv
module ninebit_uart_tx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0, bit9_i = 1'b0, par_en_i = 1'b0, tick_i = 1'b0, clr_done_i = 1'b0;
  logic [7:0] data_i = '0;
  logic txd_o, busy_o, done_o;
  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  ninebit_uart_tx #(.DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .data_i(data_i), .bit9_i(bit9_i),
    .par_en_i(par_en_i), .tick_i(tick_i), .clr_done_i(clr_done_i),
    .txd_o(txd_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic pe, input logic collide);
    logic [10:0] exp;
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    exp[0] = 1'b0;
    exp[8:1] = d;
    exp[9] = pe ? logic'(ones % 2) : b9;
    exp[10] = 1'b1;
    @(negedge clk); load_i = 1'b1; data_i = d; bit9_i = b9; par_en_i = pe;
    @(negedge clk); load_i = 1'b0; bit9_i = ~b9; par_en_i = ~pe;
    chk(busy_o, 1, "R2 busy after load");
    chk(txd_o, 1, "R2 line high before first tick");
    @(negedge clk);
    chk(txd_o, 1, "R2 line still high");
    for (int k = 0; k < 11; k++) begin
      tick_i = 1'b1;
      if (collide && k == 10) clr_done_i = 1'b1;
      @(negedge clk); tick_i = 1'b0; clr_done_i = 1'b0;
      chk(txd_o, exp[k], (k == 9) ? (pe ? "R6 parity bit" : "R5 software ninth bit") : "R4 frame bit");
      if (k == 10) chk(done_o, 1, "R7 done at stop start");
      else chk(done_o, 0, "R7 done not early");
      if (k == 4) begin load_i = 1'b1; data_i = ~d; end
      @(negedge clk); load_i = 1'b0;
      chk(txd_o, exp[k], "R3 bit held between ticks");
      @(negedge clk);
    end
    tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    chk(busy_o, 0, "R10 busy drops");
    chk(txd_o, 1, "R10 line idle");
    @(negedge clk); @(negedge clk);
    chk(busy_o, 0, "R9 no second frame");
    chk(done_o, 1, "R8 done holds");
    clr_done_i = 1'b1;
    @(negedge clk); clr_done_i = 1'b0;
    chk(done_o, 0, "R8 clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(txd_o, 1, "R1 line");
    chk(busy_o, 0, "R1 busy");
    chk(done_o, 0, "R1 done");
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd_o, 1, "R1 line after release");
    send(8'hA5, 1'b1, 1'b0, 1'b1);
    for (int pe = 0; pe < 2; pe++)
      for (int b = 0; b < 2; b++)
        for (int d = 0; d < 256; d++)
          send(8'(d), 1'(b), 1'(pe), 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule